// File: doc/BRIEF.md
# Coalescing Associative Write Buffer

This block sits between a processor's store path and a single-word memory write port. Stores are parked in a small fully associative buffer and written to memory one word at a time in the background, so a store costs the processor one cycle rather than one full memory write. Loads probe every parked entry in parallel, and a hit hands back the buffered word, so a load never reads a stale value from behind the buffer.

A store whose address is already parked replaces that entry's data and keeps the entry's place in line. A store to a fresh address claims the slot at the tail of a circular queue. When all slots are occupied, a store to a fresh address is refused and the processor holds it and retries. The oldest entry is always the one being written out. The write request stays raised, with address and data frozen, until the memory side signals completion. The entry is released on that edge, and the next write may start on the following edge. One cycle after each completion the block pulses the retired address and data, so a cache can update a matching line.

The drain engine has two states. In DR_IDLE nothing is being written. Transition T_START (DR_IDLE to DR_WRITE) is taken when at least one entry is held. In DR_WRITE the head entry is presented to memory. Transition T_WAIT (DR_WRITE to DR_WRITE) is taken while completion is low. Transition T_CHAIN (DR_WRITE to DR_WRITE) is taken on completion when more than one entry is held, and the next-oldest entry follows without a gap. Transition T_DONE (DR_WRITE to DR_IDLE) is taken on completion of the last held entry.

Top module: `wbuf_top`

## Requirements
- R1: After reset, full, mem_wr, ld_hit and upd_valid are all 0, and every load misses.
- R2: A store to an address not held, made while fewer than 4 entries are valid, is accepted (st_accept=1 in that cycle). From the next cycle, a load of that address gives ld_hit=1 and ld_data equal to the stored word.
- R3: A load whose address matches no valid entry gives ld_hit=0 and ld_data=0.
- R4: A store to an address held in a valid entry replaces that entry's data and takes no new slot. Loads then return the new word. The full flag and the number of later fresh stores that fit are unchanged.
- R5: With 4 valid entries, full=1, and a store to a fresh address gets st_accept=0 and leaves the buffer unchanged. The load of that address still misses.
- R6: A store that matches a valid entry other than the one being written is accepted even while full=1.
- R7: Entries are written to memory in the order of their first acceptance, oldest first.
- R8: While an entry is being written, mem_wr stays 1 and mem_addr/mem_data stay stable until mem_ready is sampled 1. The entry is freed on that edge. If another entry is held, mem_wr stays 1 in the next cycle with the next-oldest entry.
- R9: A store matching the entry currently being written (mem_wr=1) gets st_accept=0, and the data being written is unchanged.
- R10: In the cycle after mem_ready is sampled 1 during a write, upd_valid=1 for exactly one cycle, and upd_addr/upd_data carry the retired entry.
- R11: A merged store keeps its entry's original position in the drain order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_req | input | 1 | Store request this cycle |
| st_addr | input | 32 | Store word address |
| st_data | input | 32 | Store data |
| st_accept | output | 1 | Store taken on this edge; 0 means retry |
| full | output | 1 | All four entries valid |
| ld_addr | input | 32 | Load probe address |
| ld_hit | output | 1 | A valid entry matches ld_addr |
| ld_data | output | 32 | Matching entry's data, 0 on miss |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory write completion |
| upd_valid | output | 1 | One-cycle pulse after a completed write |
| upd_addr | output | 32 | Retired entry address |
| upd_data | output | 32 | Retired entry data |

## Verification
The bench goes after a merge aimed at the head entry while it is being written. A design that accepted it would change mem_data in the middle of a handshake. It also merges into a non-head entry while the buffer is full and then checks the drain order. A design that re-queued merged stores would drain that word last, and one that allocated a new slot would report full wrongly afterwards. Drains are swept over several completion latencies, with back-to-back writes and a merge into a not-yet-written head. These cases catch a dropped or doubled entry, a gap or overlap between chained writes, a missing or mistimed update pulse, and loads that still hit a freed entry.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int WB_ADDR_W = 32;
    localparam int WB_DATA_W = 32;

    typedef struct packed {
        logic                 vld;
        logic [WB_ADDR_W-1:0] addr;
        logic [WB_DATA_W-1:0] data;
    } wb_entry_t;

    typedef enum logic [0:0] {
        DR_IDLE  = 1'b0,
        DR_WRITE = 1'b1
    } drain_state_e;
endpackage

// File: rtl/wbuf_match.sv
module wbuf_match
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  wb_entry_t [DEPTH-1:0]     ents,
    input  logic [WB_ADDR_W-1:0]      key,
    output logic [DEPTH-1:0]          hit_vec,
    output logic                      hit,
    output logic [WB_DATA_W-1:0]      hit_data
);
    // parallel compare of the key against every valid entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = ents[g].vld && (ents[g].addr == key);
    end

    assign hit = |hit_vec;

    // and-or select; at most one entry can match
    always_comb begin
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            hit_data = hit_data | (hit_vec[i] ? ents[i].data : '0);
        end
    end
endmodule

// File: rtl/wbuf_store.sv
module wbuf_store
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc,
    input  logic [WB_ADDR_W-1:0]      alloc_addr,
    input  logic [WB_DATA_W-1:0]      alloc_data,
    input  logic                      merge,
    input  logic [DEPTH-1:0]          merge_vec,
    input  logic [WB_DATA_W-1:0]      merge_data,
    input  logic                      retire,
    output wb_entry_t [DEPTH-1:0]     ents,
    output logic [IDX_W-1:0]          head_idx,
    output logic [CNT_W-1:0]          count
);
    wb_entry_t [DEPTH-1:0] ents_q;
    logic [IDX_W-1:0]      head_q;
    logic [IDX_W-1:0]      tail_q;
    logic [CNT_W-1:0]      count_q;
    logic [DEPTH-1:0]      vld_vec;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + IDX_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ents_q  <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (alloc) begin
                ents_q[tail_q].vld  <= 1'b1;
                ents_q[tail_q].addr <= alloc_addr;
                ents_q[tail_q].data <= alloc_data;
                tail_q              <= bump(tail_q);
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (merge && merge_vec[i]) begin
                    ents_q[i].data <= merge_data;
                end
            end
            if (retire) begin
                ents_q[head_q].vld <= 1'b0;
                head_q             <= bump(head_q);
            end
            count_q <= count_q + CNT_W'(alloc) - CNT_W'(retire);
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld_vec[i] = ents_q[i].vld;
        end
    end

    assign ents     = ents_q;
    assign head_idx = head_q;
    assign count    = count_q;

    // R5: occupancy never exceeds the number of slots
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // R4: valid bits and the queue occupancy agree (merges take no slot)
    a_r4_slots_agree: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vld_vec) == int'(count_q));

    // R7: the head entry is valid whenever the queue is non-empty
    a_r7_head_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != '0) |-> ents_q[head_q].vld);
endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain
    import wbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic more,
    input  logic mem_ready,
    output logic mem_wr,
    output logic retire
);
    drain_state_e state_q;
    drain_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: T_START, T_WAIT, T_CHAIN, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE: begin
                if (pending) state_d = DR_WRITE;
            end
            DR_WRITE: begin
                if (mem_ready && !more) state_d = DR_IDLE;
            end
            default: state_d = DR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_wr = 1'b0;
        retire = 1'b0;
        unique case (state_q)
            DR_IDLE: begin
                mem_wr = 1'b0;
            end
            DR_WRITE: begin
                mem_wr = 1'b1;
                retire = mem_ready;
            end
            default: begin
                mem_wr = 1'b0;
            end
        endcase
    end

    // R8: a write without completion stays in progress on the next edge
    a_r8_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DR_WRITE && !mem_ready) |=> (state_q == DR_WRITE));

    // R8: a write is only started when an entry is held
    a_r8_start_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DR_IDLE && !pending) |=> (state_q == DR_IDLE));
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_req,
    input  logic [WB_ADDR_W-1:0] st_addr,
    input  logic [WB_DATA_W-1:0] st_data,
    output logic                 st_accept,
    output logic                 full,
    input  logic [WB_ADDR_W-1:0] ld_addr,
    output logic                 ld_hit,
    output logic [WB_DATA_W-1:0] ld_data,
    output logic                 mem_wr,
    output logic [WB_ADDR_W-1:0] mem_addr,
    output logic [WB_DATA_W-1:0] mem_data,
    input  logic                 mem_ready,
    output logic                 upd_valid,
    output logic [WB_ADDR_W-1:0] upd_addr,
    output logic [WB_DATA_W-1:0] upd_data
);
    wb_entry_t [DEPTH-1:0] ents;
    logic [IDX_W-1:0]      head_idx;
    logic [CNT_W-1:0]      count;
    logic [DEPTH-1:0]      st_hit_vec;
    logic                  st_hit;
    logic [WB_DATA_W-1:0]  st_hit_data;
    logic [DEPTH-1:0]      ld_hit_vec;
    logic                  head_busy;
    logic                  alloc;
    logic                  merge;
    logic                  retire;
    logic                  pending;
    logic                  more;

    wbuf_match #(.DEPTH(DEPTH)) u_st_match (
        .ents     (ents),
        .key      (st_addr),
        .hit_vec  (st_hit_vec),
        .hit      (st_hit),
        .hit_data (st_hit_data)
    );

    wbuf_match #(.DEPTH(DEPTH)) u_ld_match (
        .ents     (ents),
        .key      (ld_addr),
        .hit_vec  (ld_hit_vec),
        .hit      (ld_hit),
        .hit_data (ld_data)
    );

    assign full      = (count == CNT_W'(DEPTH));
    assign pending   = (count != '0);
    assign more      = (count > CNT_W'(1));
    assign head_busy = mem_wr && st_hit_vec[head_idx];
    assign st_accept = st_req && (st_hit ? !head_busy : !full);
    assign merge     = st_accept && st_hit;
    assign alloc     = st_accept && !st_hit;

    wbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (alloc),
        .alloc_addr (st_addr),
        .alloc_data (st_data),
        .merge      (merge),
        .merge_vec  (st_hit_vec),
        .merge_data (st_data),
        .retire     (retire),
        .ents       (ents),
        .head_idx   (head_idx),
        .count      (count)
    );

    wbuf_drain u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .more      (more),
        .mem_ready (mem_ready),
        .mem_wr    (mem_wr),
        .retire    (retire)
    );

    assign mem_addr = ents[head_idx].addr;
    assign mem_data = ents[head_idx].data;

    // one-cycle update for the cache, registered off the completion edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_addr  <= '0;
            upd_data  <= '0;
        end else begin
            upd_valid <= retire;
            if (retire) begin
                upd_addr <= mem_addr;
                upd_data <= mem_data;
            end
        end
    end

    // R8: address and data are frozen while a write waits for completion
    a_r8_stable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_data)));

    // R10: update pulse only follows a completed write
    a_r10_update_follows: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(mem_wr && mem_ready));

    // R4: no two valid entries share an address
    a_r4_unique_store_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_hit_vec));

    // R2: a load probe matches at most one entry
    a_r2_unique_load_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_hit_vec));

    // R9: the entry being written never changes data during the handshake
    a_r9_head_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready && st_req && (st_addr == mem_addr)) |-> !st_accept);
endmodule

// File: tb/wbuf_top_tb.sv
module wbuf_top_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_req = 1'b0;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic        st_accept;
    logic        full;
    logic [31:0] ld_addr = '0;
    logic        ld_hit;
    logic [31:0] ld_data;
    logic        mem_wr;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic        mem_ready = 1'b0;
    logic        upd_valid;
    logic [31:0] upd_addr;
    logic [31:0] upd_data;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_P/2) clk = ~clk;

    wbuf_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_req(st_req), .st_addr(st_addr), .st_data(st_data),
        .st_accept(st_accept), .full(full),
        .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ready(mem_ready),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_data(upd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // step to just after the next rising edge
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d,
                            input bit exp_acc, input string req);
        st_req = 1'b1; st_addr = a; st_data = d;
        #1;
        chk(st_accept == exp_acc, req, 32'(st_accept), 32'(exp_acc));
        step();
        st_req = 1'b0;
    endtask

    task automatic do_load(input logic [31:0] a, input bit exp_hit,
                           input logic [31:0] exp_d, input string req);
        ld_addr = a;
        #1;
        chk(ld_hit == exp_hit, req, 32'(ld_hit), 32'(exp_hit));
        chk(ld_data == exp_d, req, ld_data, exp_d);
    endtask

    // complete the current write and check the update pulse
    task automatic drain_one(input logic [31:0] a, input logic [31:0] d,
                             input string req);
        #1;
        chk(mem_wr == 1'b1, req, 32'(mem_wr), 32'd1);
        chk(mem_addr == a, req, mem_addr, a);
        chk(mem_data == d, req, mem_data, d);
        mem_ready = 1'b1;
        step();
        mem_ready = 1'b0;
        #1;
        chk(upd_valid == 1'b1, "R10 pulse", 32'(upd_valid), 32'd1);
        chk(upd_addr == a, "R10 addr", upd_addr, a);
        chk(upd_data == d, "R10 data", upd_data, d);
        step();
        #1;
        chk(upd_valid == 1'b0, "R10 single cycle", 32'(upd_valid), 32'd0);
    endtask

    initial begin : watchdog
        #(CLK_P * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] a [4];
        logic [31:0] d [4];
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        #1;
        chk(full == 1'b0, "R1 full", 32'(full), 32'd0);
        chk(mem_wr == 1'b0, "R1 mem_wr", 32'(mem_wr), 32'd0);
        chk(upd_valid == 1'b0, "R1 upd_valid", 32'(upd_valid), 32'd0);
        for (int i = 0; i < 8; i++) begin
            do_load(32'h40 * i, 1'b0, 32'd0, "R1 R3 miss after reset");
        end

        // fill with mem_ready held low: R2, R5
        for (int i = 0; i < 4; i++) begin
            a[i] = 32'h0000_1000 + 32'(i) * 4;
            d[i] = 32'hA500_0000 + 32'(i) * 32'h11;
        end
        for (int i = 0; i < 4; i++) begin
            #1;
            chk(full == 1'b0, "R5 not full yet", 32'(full), 32'd0);
            do_store(a[i], d[i], 1'b1, "R2 accept fresh");
            for (int j = 0; j <= i; j++) begin
                do_load(a[j], 1'b1, d[j], "R2 forward");
            end
            do_load(32'h0000_2000, 1'b0, 32'd0, "R3 miss");
        end
        #1;
        chk(full == 1'b1, "R5 full", 32'(full), 32'd1);
        do_store(32'h0000_3000, 32'hDEAD_0001, 1'b0, "R5 reject fresh when full");
        do_load(32'h0000_3000, 1'b0, 32'd0, "R5 rejected store absent");

        // R8 hold: write of oldest entry waits with stable lines
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(mem_wr == 1'b1, "R8 hold wr", 32'(mem_wr), 32'd1);
            chk(mem_addr == a[0], "R7 R8 oldest first", mem_addr, a[0]);
            step();
        end

        // R9 merge into head under write rejected
        do_store(a[0], 32'hBAD0_BAD0, 1'b0, "R9 reject head merge");
        #1;
        chk(mem_data == d[0], "R9 head data unchanged", mem_data, d[0]);
        do_load(a[0], 1'b1, d[0], "R9 load sees old data");

        // R6 R4 merge into a non-head entry while full
        do_store(a[2], 32'h5555_AAAA, 1'b1, "R6 merge while full");
        d[2] = 32'h5555_AAAA;
        do_load(a[2], 1'b1, d[2], "R4 merged data forwarded");
        #1;
        chk(full == 1'b1, "R4 no new slot", 32'(full), 32'd1);

        // retire oldest, chain continues
        drain_one(a[0], d[0], "R7 R8 drain oldest");
        #1;
        chk(full == 1'b0, "R8 entry freed", 32'(full), 32'd0);
        do_load(a[0], 1'b0, 32'd0, "R8 freed entry misses");
        do_store(32'h0000_1100, 32'h0F0F_0F0F, 1'b1, "R2 accept after free");
        #1;
        chk(full == 1'b1, "R4 exactly one slot was free", 32'(full), 32'd1);
        drain_one(a[1], d[1], "R8 chained write");
        drain_one(a[2], d[2], "R11 merged keeps age");
        drain_one(a[3], d[3], "R7 order");
        drain_one(32'h0000_1100, 32'h0F0F_0F0F, "R7 newest last");
        #1;
        chk(mem_wr == 1'b0, "R8 idle when empty", 32'(mem_wr), 32'd0);

        // R4 merge into head before its write starts
        do_store(32'h0000_0800, 32'h1111_1111, 1'b1, "R2 accept");
        do_store(32'h0000_0800, 32'h2222_2222, 1'b1, "R4 merge before write");
        drain_one(32'h0000_0800, 32'h2222_2222, "R4 merged data written");
        #1;
        chk(mem_wr == 1'b0, "R4 single write for merged", 32'(mem_wr), 32'd0);
        do_load(32'h0000_0800, 1'b0, 32'd0, "R8 drained entry misses");

        // sweep over completion latency: R7 R8
        for (int lat = 0; lat < 4; lat++) begin
            for (int i = 0; i < 4; i++) begin
                a[i] = 32'h0001_0000 + 32'(lat) * 32'h100 + 32'(3 - i) * 8;
                d[i] = {16'(lat), 16'(i)} ^ 32'hC3C3_0000;
                do_store(a[i], d[i], 1'b1, "R2 sweep fill");
            end
            #1;
            chk(full == 1'b1, "R5 sweep full", 32'(full), 32'd1);
            for (int i = 0; i < 4; i++) begin
                for (int w = 0; w < lat; w++) begin
                    #1;
                    chk(mem_addr == a[i], "R8 sweep stable", mem_addr, a[i]);
                    step();
                end
                drain_one(a[i], d[i], "R7 sweep order");
            end
            #1;
            chk(mem_wr == 1'b0, "R8 sweep idle", 32'(mem_wr), 32'd0);
            chk(full == 1'b0, "R8 sweep empty", 32'(full), 32'd0);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule